// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers interrupt events from a set of peripheral sources and decides whether one of them may be taken by the processor. Each source owns a latched request bit and a 3-bit programmable priority level. The processor side presents a global enable input and its current 3-bit priority threshold. A source qualifies only when the enable is high, its request bit is set, and its own level is strictly above the threshold.

When one or more sources qualify, the controller registers a winner: the highest level wins, and among equal levels the lowest source index wins. The accept strobe, winner index and winner level are then held steady until the processor returns a one-cycle acknowledge. That acknowledge clears the winner's request bit, and arbitration resumes on the following cycle. A small register port lets software read every request bit, clear request bits by writing zeros, and write or read back each source's level.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `acceptValid` is 0, every bit of `reqStatus` is 0 and every source level reads back as 0.
- R2: A one-cycle pulse on `srcEvent[i]` sets request bit i at that clock edge, and it is visible on `reqStatus[i]` from the next cycle on.
- R3: A software clear (`clrWrEn` high) clears each request bit whose `clrWrData` bit is 0 and leaves every bit whose `clrWrData` bit is 1 unchanged. If a source event and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R4: A source is eligible only when `reqStatus[i]`=1 and its level is strictly greater than `cpuLevel` (3-bit, 0..7). A level of 0 is never eligible, and `cpuLevel`=7 blocks every source.
- R5: While `globalEn` is 0, no new accept is raised, whatever the pending requests are.
- R6: Among eligible sources, the highest level wins. Equal levels are resolved in favour of the lowest source index.
- R7: `acceptValid` rises on the clock edge after a cycle in which some source was eligible and no accept was held. After that, `acceptValid`, `acceptIdx` and `acceptLevel` stay unchanged until an acknowledge, even if higher-level requests arrive or the winner's bit is cleared by software.
- R8: `ackPulse` while `acceptValid`=1 clears the winner's request bit and drops `acceptValid` at the same edge. A new event on that source in the same cycle leaves the bit set. An `ackPulse` while `acceptValid`=0 has no effect.
- R9: Level writes never change request bits, and request clears never change level fields.
- R10: `lvlWrEn` writes the 3-bit `lvlWrData` into the level of source `lvlWrIdx`. `lvlRdData` returns the level of source `lvlRdIdx`, and returns 0 for an index at or above the source count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcEvent | input | NUM_SRC | One-cycle event pulse per source |
| globalEn | input | 1 | Global maskable-interrupt enable |
| cpuLevel | input | LVL_W | Current processor priority threshold |
| ackPulse | input | 1 | Acknowledge of the held accept |
| clrWrEn | input | 1 | Request-clear write strobe |
| clrWrData | input | NUM_SRC | Clear mask, 0 clears, 1 keeps |
| lvlWrEn | input | 1 | Level write strobe |
| lvlWrIdx | input | IDX_W | Source index for level write |
| lvlWrData | input | LVL_W | Level value to write |
| lvlRdIdx | input | IDX_W | Source index for level read |
| lvlRdData | output | LVL_W | Level of the selected source |
| reqStatus | output | NUM_SRC | Current request bits |
| acceptValid | output | 1 | Accept held for the processor |
| acceptIdx | output | IDX_W | Winning source index |
| acceptLevel | output | LVL_W | Winning source level |

## Verification
The bench builds the controller with six sources and 3-bit levels. With six sources the 3-bit index has two codes above the last source, so the bench exercises the out-of-range read-back path, and every level value from 0 to 7 can be given to some source. With these values the bench covers level ties, a level-7 source tested against the top threshold, and a level-0 source tested against threshold 0. It also covers acknowledge colliding with a fresh event, and clear writes colliding with events.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef struct packed {
    logic loadAccept;
    logic dropAccept;
    logic ackClear;
  } ctrlStrobe_t;
endpackage

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_SRC-1:0]       elig,
  input  logic [NUM_SRC*LVL_W-1:0] lvlFlat,
  output logic                     anyWin,
  output logic [IDX_W-1:0]         winIdx,
  output logic [LVL_W-1:0]         winLvl
);
  // Linear scan: a later source replaces the current pick only on a strictly
  // higher level, so ties stay with the lowest index.
  always_comb begin
    anyWin = 1'b0;
    winIdx = '0;
    winLvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!anyWin || (lvlFlat[i*LVL_W +: LVL_W] > winLvl))) begin
        anyWin = 1'b1;
        winIdx = IDX_W'(i);
        winLvl = lvlFlat[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/prio_irq_datapath.sv
module prio_irq_datapath
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic               globalEn,
  input  logic [LVL_W-1:0]   cpuLevel,
  input  logic               clrWrEn,
  input  logic [NUM_SRC-1:0] clrWrData,
  input  logic               lvlWrEn,
  input  logic [IDX_W-1:0]   lvlWrIdx,
  input  logic [LVL_W-1:0]   lvlWrData,
  input  logic [IDX_W-1:0]   lvlRdIdx,
  input  ctrlStrobe_t        strobe,
  output logic               winValid,
  output logic [LVL_W-1:0]   lvlRdData,
  output logic [NUM_SRC-1:0] reqStatus,
  output logic               acceptValid,
  output logic [IDX_W-1:0]   acceptIdx,
  output logic [LVL_W-1:0]   acceptLevel
);
  logic [NUM_SRC-1:0]       reqReg;
  logic [LVL_W-1:0]         lvlReg [NUM_SRC];
  logic [NUM_SRC*LVL_W-1:0] lvlFlat;
  logic [NUM_SRC-1:0]       elig;
  logic [IDX_W-1:0]         winIdx;
  logic [LVL_W-1:0]         winLvl;

  // Request bits: an event wins over any clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqReg <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (srcEvent[i])
          reqReg[i] <= 1'b1;
        else if ((strobe.ackClear && (acceptIdx == IDX_W'(i))) ||
                 (clrWrEn && !clrWrData[i]))
          reqReg[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) lvlReg[i] <= '0;
    end else if (lvlWrEn && (int'(lvlWrIdx) < NUM_SRC)) begin
      lvlReg[lvlWrIdx] <= lvlWrData;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    assign lvlFlat[g*LVL_W +: LVL_W] = lvlReg[g];
    assign elig[g] = globalEn && reqReg[g] && (lvlReg[g] > cpuLevel);
  end

  prio_irq_arb #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) arb_i (
    .elig    (elig),
    .lvlFlat (lvlFlat),
    .anyWin  (winValid),
    .winIdx  (winIdx),
    .winLvl  (winLvl)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acceptValid <= 1'b0;
      acceptIdx   <= '0;
      acceptLevel <= '0;
    end else if (strobe.loadAccept) begin
      acceptValid <= 1'b1;
      acceptIdx   <= winIdx;
      acceptLevel <= winLvl;
    end else if (strobe.dropAccept) begin
      acceptValid <= 1'b0;
    end
  end

  assign reqStatus = reqReg;
  assign lvlRdData = (int'(lvlRdIdx) < NUM_SRC) ? lvlReg[lvlRdIdx] : '0;
endmodule

// File: rtl/prio_irq_fsm.sv
module prio_irq_fsm
  import prio_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        winValid,
  input  logic        ackPulse,
  output ctrlStrobe_t strobe
);
  typedef enum logic {ST_IDLE, ST_HELD} state_t;
  state_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    case (state)
      ST_IDLE: if (winValid) begin
        strobe.loadAccept = 1'b1;
        stateNxt          = ST_HELD;
      end
      ST_HELD: if (ackPulse) begin
        strobe.ackClear   = 1'b1;
        strobe.dropAccept = 1'b1;
        stateNxt          = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic               globalEn,
  input  logic [LVL_W-1:0]   cpuLevel,
  input  logic               ackPulse,
  input  logic               clrWrEn,
  input  logic [NUM_SRC-1:0] clrWrData,
  input  logic               lvlWrEn,
  input  logic [IDX_W-1:0]   lvlWrIdx,
  input  logic [LVL_W-1:0]   lvlWrData,
  input  logic [IDX_W-1:0]   lvlRdIdx,
  output logic [LVL_W-1:0]   lvlRdData,
  output logic [NUM_SRC-1:0] reqStatus,
  output logic               acceptValid,
  output logic [IDX_W-1:0]   acceptIdx,
  output logic [LVL_W-1:0]   acceptLevel
);
  ctrlStrobe_t strobe;
  logic        winValid;

  prio_irq_fsm fsm_i (
    .clk      (clk),
    .rstN     (rstN),
    .winValid (winValid),
    .ackPulse (ackPulse),
    .strobe   (strobe)
  );

  prio_irq_datapath #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .srcEvent    (srcEvent),
    .globalEn    (globalEn),
    .cpuLevel    (cpuLevel),
    .clrWrEn     (clrWrEn),
    .clrWrData   (clrWrData),
    .lvlWrEn     (lvlWrEn),
    .lvlWrIdx    (lvlWrIdx),
    .lvlWrData   (lvlWrData),
    .lvlRdIdx    (lvlRdIdx),
    .strobe      (strobe),
    .winValid    (winValid),
    .lvlRdData   (lvlRdData),
    .reqStatus   (reqStatus),
    .acceptValid (acceptValid),
    .acceptIdx   (acceptIdx),
    .acceptLevel (acceptLevel)
  );
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcEvent,
  input logic               globalEn,
  input logic [LVL_W-1:0]   cpuLevel,
  input logic               ackPulse,
  input logic               clrWrEn,
  input logic [NUM_SRC-1:0] clrWrData,
  input logic [NUM_SRC-1:0] reqStatus,
  input logic               acceptValid,
  input logic [IDX_W-1:0]   acceptIdx,
  input logic [LVL_W-1:0]   acceptLevel
);
  // R2
  event_sets_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcEvent != '0) |=> ((reqStatus & $past(srcEvent)) == $past(srcEvent)));

  // R3
  clear_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrWrEn |=> ((reqStatus & ~$past(clrWrData) & ~$past(srcEvent)) == '0));

  // R4
  level_above_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(acceptValid) |-> ((acceptLevel > $past(cpuLevel)) && (acceptLevel != '0)));

  // R5
  no_accept_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!globalEn && !acceptValid) |=> !acceptValid);

  // R7
  accept_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acceptValid && !ackPulse) |=>
      (acceptValid && $stable(acceptIdx) && $stable(acceptLevel)));

  // R8
  ack_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acceptValid && ackPulse) |=> !acceptValid);

  // R8
  ack_clears_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acceptValid && ackPulse && !srcEvent[acceptIdx]) |=> !reqStatus[$past(acceptIdx)]);
endmodule

bind prio_irq_ctrl prio_irq_chk #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .srcEvent    (srcEvent),
  .globalEn    (globalEn),
  .cpuLevel    (cpuLevel),
  .ackPulse    (ackPulse),
  .clrWrEn     (clrWrEn),
  .clrWrData   (clrWrData),
  .reqStatus   (reqStatus),
  .acceptValid (acceptValid),
  .acceptIdx   (acceptIdx),
  .acceptLevel (acceptLevel)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  localparam int NS = 6;
  localparam int LW = 3;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NS-1:0] srcEvent;
  logic          globalEn;
  logic [LW-1:0] cpuLevel;
  logic          ackPulse;
  logic          clrWrEn;
  logic [NS-1:0] clrWrData;
  logic          lvlWrEn;
  logic [IW-1:0] lvlWrIdx;
  logic [LW-1:0] lvlWrData;
  logic [IW-1:0] lvlRdIdx;
  logic [LW-1:0] lvlRdData;
  logic [NS-1:0] reqStatus;
  logic          acceptValid;
  logic [IW-1:0] acceptIdx;
  logic [LW-1:0] acceptLevel;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(NS), .LVL_W(LW)) dut_i (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .globalEn(globalEn),
    .cpuLevel(cpuLevel), .ackPulse(ackPulse), .clrWrEn(clrWrEn),
    .clrWrData(clrWrData), .lvlWrEn(lvlWrEn), .lvlWrIdx(lvlWrIdx),
    .lvlWrData(lvlWrData), .lvlRdIdx(lvlRdIdx), .lvlRdData(lvlRdData),
    .reqStatus(reqStatus), .acceptValid(acceptValid), .acceptIdx(acceptIdx),
    .acceptLevel(acceptLevel)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulseEv(input logic [NS-1:0] m);
    srcEvent = m; tick(); srcEvent = '0;
  endtask

  task automatic clrW(input logic [NS-1:0] m);
    clrWrEn = 1'b1; clrWrData = m; tick(); clrWrEn = 1'b0; clrWrData = '1;
  endtask

  task automatic setLvl(input int idx, input int v);
    lvlWrEn = 1'b1; lvlWrIdx = IW'(idx); lvlWrData = LW'(v); tick(); lvlWrEn = 1'b0;
  endtask

  task automatic rdLvl(input int idx, output int v);
    lvlRdIdx = IW'(idx); #0.5; v = int'(lvlRdData);
  endtask

  task automatic ack();
    ackPulse = 1'b1; tick(); ackPulse = 1'b0;
  endtask

  task automatic expAccept(input string tag, input int idx, input int lvl);
    chk({tag, " valid"}, int'(acceptValid), 1);
    chk({tag, " idx"}, int'(acceptIdx), idx);
    chk({tag, " level"}, int'(acceptLevel), lvl);
  endtask

  task automatic t_reset();
    int v;
    chk("R1 acceptValid", int'(acceptValid), 0);
    chk("R1 reqStatus", int'(reqStatus), 0);
    for (int i = 0; i < NS; i++) begin
      rdLvl(i, v);
      chk("R1 level", v, 0);
    end
  endtask

  task automatic t_setClear();
    globalEn = 1'b0;
    pulseEv(6'b000101);
    chk("R2 set", int'(reqStatus), 'b000101);
    clrW(6'b111110);
    chk("R3 clear bit0", int'(reqStatus), 'b000100);
    clrW(6'b111111);
    chk("R3 ones ignored", int'(reqStatus), 'b000100);
    srcEvent = 6'b000010; clrWrEn = 1'b1; clrWrData = '0; tick();
    srcEvent = '0; clrWrEn = 1'b0; clrWrData = '1;
    chk("R3 event beats clear", int'(reqStatus), 'b000010);
    clrW('0);
    chk("R3 clear all", int'(reqStatus), 0);
  endtask

  task automatic t_levels();
    int v;
    pulseEv(6'b010000);
    setLvl(0, 3); setLvl(1, 5); setLvl(2, 5); setLvl(3, 1); setLvl(4, 7); setLvl(5, 0);
    chk("R9 level write keeps req", int'(reqStatus), 'b010000);
    rdLvl(0, v); chk("R10 level0", v, 3);
    rdLvl(4, v); chk("R10 level4", v, 7);
    rdLvl(6, v); chk("R10 out of range", v, 0);
    setLvl(7, 6);
    rdLvl(3, v); chk("R10 oob write harmless", v, 1);
    clrW('0);
    rdLvl(4, v); chk("R9 clear keeps level", v, 7);
    rdLvl(1, v); chk("R9 clear keeps level1", v, 5);
  endtask

  task automatic t_threshold();
    globalEn = 1'b0; cpuLevel = 3'd7;
    pulseEv(6'b010000);
    globalEn = 1'b1; tick(); tick();
    chk("R4 cpu 7 blocks", int'(acceptValid), 0);
    cpuLevel = 3'd6; tick();
    expAccept("R4 7 over 6", 4, 7);
    ack();
    chk("R8 ack clears", int'(reqStatus), 0);
    chk("R8 ack drops", int'(acceptValid), 0);
    cpuLevel = 3'd0;
    pulseEv(6'b100000); tick(); tick();
    chk("R4 level 0 never", int'(acceptValid), 0);
    clrW('0);
    cpuLevel = 3'd3;
    pulseEv(6'b000001); tick();
    chk("R4 equal not above", int'(acceptValid), 0);
    cpuLevel = 3'd2; tick();
    expAccept("R4 3 over 2", 0, 3);
    ack(); globalEn = 1'b0; clrW('0);
  endtask

  task automatic t_enable();
    globalEn = 1'b0; cpuLevel = 3'd0;
    pulseEv(6'b000010); tick(); tick();
    chk("R5 disabled", int'(acceptValid), 0);
    globalEn = 1'b1; tick();
    expAccept("R5 enabled", 1, 5);
    ack(); globalEn = 1'b0;
  endtask

  task automatic t_priority();
    globalEn = 1'b0; cpuLevel = 3'd0;
    pulseEv(6'b011111);
    globalEn = 1'b1; tick();
    expAccept("R6 highest", 4, 7);
    ack(); tick();
    expAccept("R6 tie low index", 1, 5);
    ack();
    chk("R8 winner bit cleared", int'(reqStatus), 'b001101);
    tick();
    expAccept("R6 tie next", 2, 5);
    ack(); tick();
    expAccept("R6 then level3", 0, 3);
    ack(); tick();
    expAccept("R6 last", 3, 1);
    ack(); globalEn = 1'b0;
    chk("R6 all served", int'(reqStatus), 0);
  endtask

  task automatic t_hold();
    globalEn = 1'b1; cpuLevel = 3'd0;
    pulseEv(6'b001000);
    chk("R7 not before edge", int'(acceptValid), 0);
    tick();
    expAccept("R7 raised", 3, 1);
    pulseEv(6'b010000); tick();
    expAccept("R7 held vs higher", 3, 1);
    clrW(6'b110111);
    chk("R7 sw clear bit3", int'(reqStatus[3]), 0);
    expAccept("R7 held after clear", 3, 1);
    ack();
    chk("R8 dropped", int'(acceptValid), 0);
    tick();
    expAccept("R7 next winner", 4, 7);
    srcEvent = 6'b010000; ackPulse = 1'b1; tick(); srcEvent = '0; ackPulse = 1'b0;
    chk("R8 event beats ack", int'(reqStatus[4]), 1);
    chk("R8 ack with event drops", int'(acceptValid), 0);
    tick();
    expAccept("R8 reaccept", 4, 7);
    globalEn = 1'b0; ack(); tick();
    chk("R5 no reaccept", int'(acceptValid), 0);
    clrW('0);
    pulseEv(6'b000010); ack();
    chk("R8 ack ignored idle", int'(reqStatus), 'b000010);
    clrW('0);
  endtask

  initial begin
    rstN = 1'b0; srcEvent = '0; globalEn = 1'b0; cpuLevel = '0; ackPulse = 1'b0;
    clrWrEn = 1'b0; clrWrData = '1; lvlWrEn = 1'b0; lvlWrIdx = '0; lvlWrData = '0;
    lvlRdIdx = '0;
    tick(); tick();
    rstN = 1'b1; tick();
    t_reset();
    t_setClear();
    t_levels();
    t_threshold();
    t_enable();
    t_priority();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule